// File: doc/BRIEF.md
# CAN Error and Overload Flag Sequencer

This block drives the transmit line of a CAN node while an error frame or an overload frame is being signalled. The protocol engine raises one of two requests, and the sequencer then owns the transmit bit until the frame has ended. It first sends a flag of `FLAG_BITS` bits. The flag level depends on the request: an error request from an error-active node gives dominant bits. An error request from an error-passive node gives recessive bits. An overload request always gives dominant bits. After the flag it sends a delimiter of `DELIM_BITS` recessive bits.

Other nodes may answer with their own flags, so the bus can stay dominant for several bit times after this node's flag has ended. The sequencer therefore releases the bus and waits for the first recessive sample. That sample is the first delimiter bit. If a dominant bit is sampled while the delimiter is being counted, the count is dropped and the wait for recessive starts again. When the last delimiter bit has been sampled, a single-cycle done pulse is raised and the block returns to idle.

All progress is paced by a one-cycle bit strobe, which marks the sample point of each bit time. The sampled receive bit is only read in a strobe cycle. Error detection, error counting and frame decoding are done elsewhere. An overload sequence leaves the error counters alone simply because the block has no path to them.

Top module: `can_flag_gen`

States:
- `ST_IDLE`: transmit is recessive. Goes to `ST_FLAG` on any request.
- `ST_FLAG`: transmit is the latched flag level. Goes to `ST_WAIT` on the last flag strobe.
- `ST_WAIT`: transmit is recessive. Goes to `ST_DELIM` on a recessive sample. Goes directly to `ST_DONE` when `DELIM_BITS` is 1.
- `ST_DELIM`: transmit is recessive. Goes back to `ST_WAIT` on a dominant sample. Goes to `ST_DONE` on the last recessive sample.
- `ST_DONE`: the done pulse. Always returns to `ST_IDLE`.

## Requirements
- R1: After reset, and whenever no sequence is active, `tx_bit` is 1 (recessive), `seq_busy` is 0 and `seq_done` is 0. Strobes and receive bits in idle have no effect.
- R2: An error request (`req_error`=1) accepted while `node_passive`=0 drives `tx_bit`=0 (dominant) for exactly `FLAG_BITS` strobes (default 6), starting in the cycle after the request.
- R3: An error request accepted while `node_passive`=1 drives `tx_bit`=1 for the `FLAG_BITS` flag strobes. `seq_busy` is 1 throughout.
- R4: An overload request (`req_overload`=1) gives a dominant flag whatever `node_passive` is. When both requests are high in the same cycle, the error request decides the flag level.
- R5: After the flag, `tx_bit` is 1. Each strobe that samples `rx_bit`=0 keeps the block waiting, so overlapping flags from other nodes lengthen the sequence by one bit each.
- R6: The first strobe with `rx_bit`=1 after the flag counts as delimiter bit 1. `seq_done` rises in the cycle after the strobe that samples the `DELIM_BITS`-th (default 8) consecutive recessive bit.
- R7: A strobe with `rx_bit`=0 during the delimiter count discards the bits counted so far and returns the block to waiting for recessive.
- R8: `seq_done` is high for exactly one cycle. In the next cycle `seq_busy` is 0 and the block is idle, even if a request is high in the done cycle.
- R9: Requests and changes of `node_passive` that arrive while a sequence is active are ignored: the flag level and the sequence length are unchanged.
- R10: Without a strobe the sequence does not advance. `tx_bit` and `seq_busy` hold between strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_error | input | 1 | Start an error flag sequence (taken in idle only) |
| req_overload | input | 1 | Start an overload flag sequence (taken in idle only) |
| node_passive | input | 1 | 1 when the node is error-passive, 0 when error-active |
| bit_strobe | input | 1 | One-cycle pulse at the sample point of each bit time |
| rx_bit | input | 1 | Sampled bus level, 0 = dominant |
| tx_bit | output | 1 | Transmit level, 0 = dominant |
| seq_busy | output | 1 | High from request acceptance up to and including the done cycle |
| seq_done | output | 1 | One-cycle pulse after the last delimiter bit |

## Verification
Two pairs of events can meet in a single cycle.

The first pair is a new request and a strobe that advances an active sequence. The bench provokes this by raising both requests together with the third strobe of every sequence, and by flipping the error state in the same cycle. The result is judged by checking that the flag level of every later bit and the cycle of the done pulse match the arithmetic model.

The second pair is the done cycle and a new request. The bench holds a request high during the done pulse and expects the block to be idle in the following cycle.

The sweep also places a dominant sample on every possible delimiter position, including the one that would otherwise have completed it. It combines each of these positions with zero to six bits of overlapping flags from other nodes. For every combination, the expected strobe of the done pulse is the flag length plus the extra dominant bits, plus the interrupted delimiter bits and the one dominant bit, plus the full delimiter.

// File: rtl/can_flag_pkg.sv
package can_flag_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FLAG,
        ST_WAIT,
        ST_DELIM,
        ST_DONE
    } flag_state_t;

    // Bus levels
    localparam logic LVL_DOMINANT  = 1'b0;
    localparam logic LVL_RECESSIVE = 1'b1;

    // Flag level chosen at request time; an error request takes precedence.
    function automatic logic pick_flag_level(input logic err_req,
                                             input logic passive);
        if (err_req && passive)
            return LVL_RECESSIVE;
        return LVL_DOMINANT;
    endfunction

endpackage

// File: rtl/flag_bit_counter.sv
module flag_bit_counter #(
    parameter int CW    = 4,
    parameter int LIMIT = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] count
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count <= '0;
        else if (clr)
            count <= '0;
        else if (inc)
            count <= count + CW'(1);
    end

    // Counter never runs past the longest field it measures (R6).
    p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        count < CW'(LIMIT))
        else $error("bit counter beyond field length");

endmodule

// File: rtl/flag_seq_fsm.sv
module flag_seq_fsm
    import can_flag_pkg::*;
#(
    parameter int FLAG_BITS  = 6,
    parameter int DELIM_BITS = 8,
    parameter int CW         = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_error,
    input  logic          req_overload,
    input  logic          node_passive,
    input  logic          bit_strobe,
    input  logic          rx_bit,
    input  logic [CW-1:0] count,
    output logic          cnt_clr,
    output logic          cnt_inc,
    output logic          tx_bit,
    output logic          seq_busy,
    output logic          seq_done
);

    localparam logic [CW-1:0] FLAG_LAST  = CW'(FLAG_BITS - 1);
    localparam logic [CW-1:0] DELIM_LAST = CW'(DELIM_BITS - 1);
    localparam bit            DELIM_ONE  = (DELIM_BITS == 1);

    flag_state_t state, state_nx;
    logic        flag_lvl;
    logic        any_req;

    assign any_req = req_error | req_overload;

    // State and flag-level register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            flag_lvl <= LVL_RECESSIVE;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && any_req)
                flag_lvl <= pick_flag_level(req_error, node_passive);
        end
    end

    // Next state and counter control
    always_comb begin
        state_nx = state;
        cnt_clr  = 1'b0;
        cnt_inc  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                cnt_clr = 1'b1;
                if (any_req)
                    state_nx = ST_FLAG;
            end
            ST_FLAG: begin
                if (bit_strobe) begin
                    if (count == FLAG_LAST) begin
                        cnt_clr  = 1'b1;
                        state_nx = ST_WAIT;
                    end else begin
                        cnt_inc = 1'b1;
                    end
                end
            end
            ST_WAIT: begin
                if (bit_strobe) begin
                    if (rx_bit == LVL_RECESSIVE) begin
                        if (DELIM_ONE) begin
                            cnt_clr  = 1'b1;
                            state_nx = ST_DONE;
                        end else begin
                            cnt_inc  = 1'b1;
                            state_nx = ST_DELIM;
                        end
                    end else begin
                        cnt_clr = 1'b1;
                    end
                end
            end
            ST_DELIM: begin
                if (bit_strobe) begin
                    if (rx_bit == LVL_DOMINANT) begin
                        cnt_clr  = 1'b1;
                        state_nx = ST_WAIT;
                    end else if (count == DELIM_LAST) begin
                        cnt_clr  = 1'b1;
                        state_nx = ST_DONE;
                    end else begin
                        cnt_inc = 1'b1;
                    end
                end
            end
            ST_DONE: begin
                cnt_clr  = 1'b1;
                state_nx = ST_IDLE;
            end
            default: begin
                cnt_clr  = 1'b1;
                state_nx = ST_IDLE;
            end
        endcase
    end

    // Outputs
    always_comb begin
        tx_bit   = LVL_RECESSIVE;
        seq_busy = 1'b1;
        seq_done = 1'b0;
        unique case (state)
            ST_IDLE:  seq_busy = 1'b0;
            ST_FLAG:  tx_bit   = flag_lvl;
            ST_WAIT:  tx_bit   = LVL_RECESSIVE;
            ST_DELIM: tx_bit   = LVL_RECESSIVE;
            ST_DONE:  seq_done = 1'b1;
            default:  seq_busy = 1'b0;
        endcase
    end

    // R10: no strobe, no movement inside a running field
    p_hold_no_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_strobe && (state == ST_FLAG || state == ST_WAIT || state == ST_DELIM))
        |=> $stable(state))
        else $error("state moved without a bit strobe");

    // R7: dominant sample during delimiter returns to the wait state
    p_dom_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DELIM && bit_strobe && !rx_bit) |=> (state == ST_WAIT))
        else $error("dominant bit did not restart delimiter wait");

    // R9: flag level is frozen while the flag is being sent
    p_flag_level_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FLAG) |=> (state != ST_FLAG || $stable(tx_bit)))
        else $error("flag level changed mid-flag");

    // R6: completion only follows a recessive sample on a strobe
    p_done_after_recessive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE) |-> ($past(bit_strobe) && $past(rx_bit)))
        else $error("done without a final recessive sample");

    // R5: waiting state releases the bus
    p_wait_recessive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT || state == ST_DELIM) |-> tx_bit)
        else $error("bus not released after flag");

endmodule

// File: rtl/can_flag_gen.sv
module can_flag_gen #(
    parameter int FLAG_BITS  = 6,
    parameter int DELIM_BITS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_error,
    input  logic req_overload,
    input  logic node_passive,
    input  logic bit_strobe,
    input  logic rx_bit,
    output logic tx_bit,
    output logic seq_busy,
    output logic seq_done
);

    localparam int LONGEST = (FLAG_BITS > DELIM_BITS) ? FLAG_BITS : DELIM_BITS;
    localparam int CW      = $clog2(LONGEST + 1);

    logic [CW-1:0] count;
    logic          cnt_clr;
    logic          cnt_inc;

    flag_bit_counter #(
        .CW    (CW),
        .LIMIT (LONGEST)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .count (count)
    );

    flag_seq_fsm #(
        .FLAG_BITS  (FLAG_BITS),
        .DELIM_BITS (DELIM_BITS),
        .CW         (CW)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_error    (req_error),
        .req_overload (req_overload),
        .node_passive (node_passive),
        .bit_strobe   (bit_strobe),
        .rx_bit       (rx_bit),
        .count        (count),
        .cnt_clr      (cnt_clr),
        .cnt_inc      (cnt_inc),
        .tx_bit       (tx_bit),
        .seq_busy     (seq_busy),
        .seq_done     (seq_done)
    );

    // R1: idle node never drives dominant
    p_idle_recessive_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_busy |-> (tx_bit && !seq_done))
        else $error("idle node not recessive");

    // R8: done is a single pulse followed by idle
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> (!seq_done && !seq_busy))
        else $error("done pulse too long or block not idle");

endmodule

// File: tb/can_flag_gen_test.sv
module can_flag_gen_test;

    localparam int FLAG  = 6;
    localparam int DELIM = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_error = 1'b0;
    logic req_overload = 1'b0;
    logic node_passive = 1'b0;
    logic bit_strobe = 1'b0;
    logic rx_bit = 1'b1;
    logic tx_bit;
    logic seq_busy;
    logic seq_done;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    can_flag_gen #(.FLAG_BITS(FLAG), .DELIM_BITS(DELIM)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_error    (req_error),
        .req_overload (req_overload),
        .node_passive (node_passive),
        .bit_strobe   (bit_strobe),
        .rx_bit       (rx_bit),
        .tx_bit       (tx_bit),
        .seq_busy     (seq_busy),
        .seq_done     (seq_done)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Bus level seen on strobe b (1-based) of a sequence
    function automatic logic bus_at(input int b, input int extra, input int brk);
        int j;
        int k;
        if (b <= FLAG) return 1'b0;
        j = b - FLAG;
        if (j <= extra) return 1'b0;
        k = j - extra;
        if (brk > 0 && k == brk + 1) return 1'b0;
        return 1'b1;
    endfunction

    task automatic run_seq(input bit e, input bit o, input bit pas,
                           input int extra, input int brk);
        int   total;
        logic exp_flag;
        logic exp_tx;
        total    = FLAG + extra + ((brk > 0) ? brk + 1 : 0) + DELIM;
        exp_flag = e & pas;   // R4: error wins; overload alone is dominant
        @(negedge clk);
        req_error    = e;
        req_overload = o;
        node_passive = pas;
        @(negedge clk);
        req_error    = 1'b0;
        req_overload = 1'b0;
        chk(seq_busy == 1'b1, "R2 busy after request", seq_busy, 1);
        for (int b = 1; b <= total; b++) begin
            @(negedge clk);
            @(negedge clk);
            exp_tx = (b <= FLAG) ? exp_flag : 1'b1;
            if (b <= FLAG)
                chk(tx_bit == exp_tx, (e && pas) ? "R3 passive flag" :
                    (e ? "R2 active flag" : "R4 overload flag"), tx_bit, exp_tx);
            else
                chk(tx_bit == 1'b1, "R5 released after flag", tx_bit, 1);
            chk(seq_busy == 1'b1, "R10 busy held between strobes", seq_busy, 1);
            chk(seq_done == 1'b0, "R6 done not early", seq_done, 0);
            bit_strobe = 1'b1;
            rx_bit     = bus_at(b, extra, brk);
            if (b == 3) begin   // R9: request and state flip alongside a strobe
                req_error    = 1'b1;
                req_overload = 1'b1;
                node_passive = ~pas;
            end
            @(negedge clk);
            bit_strobe   = 1'b0;
            rx_bit       = 1'b1;
            req_error    = 1'b0;
            req_overload = 1'b0;
            node_passive = pas;
        end
        // Done cycle (brk>0 exercises R7 restart)
        chk(seq_done == 1'b1, (brk > 0) ? "R7 done after restarted delimiter" :
            "R6 done after delimiter", seq_done, 1);
        chk(tx_bit == 1'b1, "R6 recessive at done", tx_bit, 1);
        req_error = 1'b1;   // R8: request in done cycle ignored
        @(negedge clk);
        req_error = 1'b0;
        chk(seq_done == 1'b0, "R8 done single pulse", seq_done, 0);
        chk(seq_busy == 1'b0, "R8 idle after done", seq_busy, 0);
        chk(tx_bit == 1'b1, "R1 idle recessive", tx_bit, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tx_bit == 1'b1, "R1 reset tx", tx_bit, 1);
        chk(seq_busy == 1'b0, "R1 reset busy", seq_busy, 0);
        chk(seq_done == 1'b0, "R1 reset done", seq_done, 0);

        // R1: strobes with dominant bus in idle change nothing
        for (int i = 0; i < 4; i++) begin
            bit_strobe = 1'b1;
            rx_bit     = 1'b0;
            @(negedge clk);
            bit_strobe = 1'b0;
            rx_bit     = 1'b1;
            chk(seq_busy == 1'b0 && tx_bit == 1'b1, "R1 idle strobe ignored",
                {seq_busy, tx_bit}, 1);
        end

        // R10: no strobes for a long stretch keeps the flag on the bus
        @(negedge clk);
        req_error    = 1'b1;
        node_passive = 1'b0;
        @(negedge clk);
        req_error = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            chk(tx_bit == 1'b0 && seq_busy == 1'b1, "R10 flag held without strobe",
                {seq_busy, tx_bit}, 2);
        end
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk(tx_bit == 1'b1 && seq_busy == 1'b0, "R1 after re-reset",
            {seq_busy, tx_bit}, 1);

        // Sweep: request kind x error state x overlapping flags x break position
        for (int kind = 0; kind < 3; kind++) begin
            for (int pas = 0; pas < 2; pas++) begin
                for (int extra = 0; extra <= 6; extra++) begin
                    for (int brk = 0; brk < DELIM; brk++) begin
                        run_seq(kind != 1, kind != 0, pas[0], extra, brk);
                    end
                end
            end
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule